// File: doc/BRIEF.md
# Serial Shift Register Controller

This block is an 8-bit serial shift register with its own bit counter and completion flag. It sits behind a small register bus and moves a byte in or out over a serial data line while a companion clock line either carries shift pulses produced by the block or delivers shift pulses from an external device. A 3-bit mode field picks one of eight behaviours. The mode sets the data direction, the clock source, and whether the counter stops shifting after eight bits or only marks each group of eight.

The shift rate comes from one of three places. The first is a strobe from a neighbouring interval timer, which is not part of this block. The second is the system clock, one shift per cycle. The third is a rising edge on the clock line driven from outside. In shift-out modes the register rotates, so the byte that was sent is back in place once eight shifts are done. The data line holds the last bit that was sent. Software starts a counted transfer by reading or writing the data register. That access clears the flag and arms a new count of eight.

Top module: `ssr_ctrl`

## Requirements
- R1: After reset the data register reads 0, the flag and `irq` are 0, the mode is 0 and the bit counter is empty, so a counted mode does not shift until the data register is accessed.
- R2: The data register is at offset 10. The mode field is at offset 11, bits 4:2, and the other bits of that register read 0. The flag reads at offset 13, bit 2, and `irq` always equals the flag.
- R3: A read or write at offset 10 clears the flag and arms a count of 8. Any shift due in that same cycle is dropped, and a written value replaces the register contents.
- R4: In modes 0 to 3 each shift moves the register one place towards bit 7 and loads `cb2_in` into bit 0.
- R5: In modes 4 to 7 each shift rotates bit 7 into bit 0. The same bit goes to `cb2_out`, which keeps that level until the next shift.
- R6: Modes 1, 4 and 5 shift on a `tmr_tick` cycle. Modes 2 and 6 shift on every clock. Modes 0, 3 and 7 shift at the first clock edge where `cb1_in` is high after an edge where it was low, and take `cb2_in` at that edge.
- R7: In modes 1, 2, 5 and 6 shifting happens only while the count is non-zero. The eighth shift sets the flag. After that the register and `cb2_out` stay unchanged until the next access.
- R8: In modes 3 and 7 the eighth shift after an access sets the flag, and further edges keep shifting.
- R9: Mode 4 shifts without end and never sets the flag. In mode 0 the flag is held at 0.
- R10: `cb1_oe` is high in modes 1, 2, 4, 5 and 6, and `cb1_out` is low for exactly one cycle after each shift. `cb2_oe` is high in modes 4 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational on the offset) |
| tmr_tick | input | 1 | One-cycle time-out strobe from the interval timer |
| cb1_in | input | 1 | Shift clock from an external device |
| cb1_out | output | 1 | Shift clock produced by the block, idle high |
| cb1_oe | output | 1 | Drive enable for the shift clock line |
| cb2_in | input | 1 | Serial data in |
| cb2_out | output | 1 | Serial data out |
| cb2_oe | output | 1 | Drive enable for the serial data line |
| irq | output | 1 | Shift-complete flag |

## Verification
The hardest case to reach is a count that runs out and then ignores later clock events. To reach it, the bench keeps sending timer strobes or clock-line edges after the eighth shift. It then shows at the ports that `cb2_out` and the register contents did not move. A second hard case is an access that lands in the middle of a system-clock transfer. The bench writes a new byte after three shifts and checks that the next eight bits on `cb2_out` come only from the new byte. Random bytes and bit patterns from a fixed seed are applied in each mode, and each expected value is built by bench functions for rotation and serial assembly.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

   typedef enum logic [2:0] {
      SM_OFF      = 3'd0,
      SM_IN_TMR   = 3'd1,
      SM_IN_SYS   = 3'd2,
      SM_IN_EXT   = 3'd3,
      SM_OUT_FREE = 3'd4,
      SM_OUT_TMR  = 3'd5,
      SM_OUT_SYS  = 3'd6,
      SM_OUT_EXT  = 3'd7
   } ssr_mode_e;

   typedef enum logic [1:0] {
      SRC_TMR = 2'd0,
      SRC_SYS = 2'd1,
      SRC_EXT = 2'd2
   } ssr_src_e;

   function automatic ssr_src_e mode_src(input ssr_mode_e m);
      case (m)
         SM_IN_TMR, SM_OUT_FREE, SM_OUT_TMR: mode_src = SRC_TMR;
         SM_IN_SYS, SM_OUT_SYS:              mode_src = SRC_SYS;
         default:                            mode_src = SRC_EXT;
      endcase
   endfunction

   // transfer stops once the count is spent
   function automatic logic mode_counted(input ssr_mode_e m);
      mode_counted = (m == SM_IN_TMR) || (m == SM_IN_SYS) ||
                     (m == SM_OUT_TMR) || (m == SM_OUT_SYS);
   endfunction

   // count only marks groups, shifting continues
   function automatic logic mode_marks(input ssr_mode_e m);
      mode_marks = (m == SM_IN_EXT) || (m == SM_OUT_EXT);
   endfunction

   function automatic logic mode_drives_clk(input ssr_mode_e m);
      mode_drives_clk = (m == SM_IN_TMR) || (m == SM_IN_SYS) ||
                        (m == SM_OUT_FREE) || (m == SM_OUT_TMR) ||
                        (m == SM_OUT_SYS);
   endfunction

   function automatic logic mode_is_out(input ssr_mode_e m);
      mode_is_out = m[2];
   endfunction

endpackage

// File: rtl/ssr_regs.sv
module ssr_regs
   import ssr_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   parameter int SR_OFFS   = 10,
   parameter int AUX_OFFS  = 11,
   parameter int FLAG_OFFS = 13,
   parameter int MODE_LSB  = 2,
   parameter int FLAG_BIT  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [2:0]        wmode,
   input  logic [DATA_W-1:0] sr_q,
   input  logic              flag_q,
   output logic [DATA_W-1:0] rdata,
   output ssr_mode_e         mode,
   output logic              sr_wr,
   output logic              sr_acc
);

   localparam logic [ADDR_W-1:0] SR_A   = ADDR_W'(SR_OFFS);
   localparam logic [ADDR_W-1:0] AUX_A  = ADDR_W'(AUX_OFFS);
   localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_OFFS);

   logic hit_sr, hit_aux, hit_flag;

   assign hit_sr   = (addr == SR_A);
   assign hit_aux  = (addr == AUX_A);
   assign hit_flag = (addr == FLAG_A);

   assign sr_wr  = wr_en && hit_sr;
   assign sr_acc = (wr_en || rd_en) && hit_sr;

   always_ff @(posedge clk) begin
      if (!rst_n)
         mode <= SM_OFF;
      else if (wr_en && hit_aux)
         mode <= ssr_mode_e'(wmode);
   end

   always_comb begin
      rdata = '0;
      if (hit_sr)
         rdata = sr_q;
      else if (hit_aux)
         rdata[MODE_LSB +: 3] = mode;
      else if (hit_flag)
         rdata[FLAG_BIT] = flag_q;
   end

endmodule

// File: rtl/ssr_tick.sv
module ssr_tick
   import ssr_pkg::*;
#(
   parameter int SYNC_STAGES = 0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  ssr_src_e src,
   input  logic     tmr_tick,
   input  logic     cb1_in,
   output logic     tick
);

   logic cb1_s;
   logic cb1_prev;
   logic cb1_rise;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign cb1_s = cb1_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk) begin
            if (!rst_n)
               chain <= '1;
            else
               chain <= {chain[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], cb1_in} & {SYNC_STAGES{1'b1}};
         end
         assign cb1_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   // idle-high reset so a line held high after reset gives no edge
   always_ff @(posedge clk) begin
      if (!rst_n)
         cb1_prev <= 1'b1;
      else
         cb1_prev <= cb1_s;
   end

   assign cb1_rise = cb1_s && !cb1_prev;

   always_comb begin
      case (src)
         SRC_TMR: tick = tmr_tick;
         SRC_SYS: tick = 1'b1;
         default: tick = cb1_rise;
      endcase
   end

endmodule

// File: rtl/ssr_core.sv
module ssr_core
   import ssr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ssr_mode_e         mode,
   input  logic              tick,
   input  logic              sr_acc,
   input  logic              sr_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              cb2_in,
   output logic [DATA_W-1:0] sr_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              flag_q,
   output logic              cb2_q,
   output logic              pulse_q
);

   localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

   logic              counted, marks, uses_cnt, shift_en;
   logic              cnt_live;
   logic [DATA_W-1:0] sr_nxt;

   assign counted  = mode_counted(mode);
   assign marks    = mode_marks(mode);
   assign uses_cnt = counted || marks;
   assign cnt_live = (cnt_q != '0);

   assign shift_en = tick && !sr_acc && (!counted || cnt_live);

   generate
      if (DATA_W > 1) begin : g_wide
         assign sr_nxt = mode_is_out(mode) ? {sr_q[DATA_W-2:0], sr_q[DATA_W-1]}
                                           : {sr_q[DATA_W-2:0], cb2_in};
      end else begin : g_bit
         assign sr_nxt = mode_is_out(mode) ? sr_q : cb2_in;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr_q    <= '0;
         cnt_q   <= '0;
         flag_q  <= 1'b0;
         cb2_q   <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= shift_en && mode_drives_clk(mode);

         if (sr_wr)
            sr_q <= wdata;
         else if (shift_en)
            sr_q <= sr_nxt;

         if (shift_en && mode_is_out(mode))
            cb2_q <= sr_q[DATA_W-1];

         if (sr_acc)
            cnt_q <= FULL;
         else if (shift_en && uses_cnt && cnt_live)
            cnt_q <= cnt_q - LAST;

         if (mode == SM_OFF)
            flag_q <= 1'b0;
         else if (sr_acc)
            flag_q <= 1'b0;
         else if (shift_en && uses_cnt && (cnt_q == LAST))
            flag_q <= 1'b1;
      end
   end

endmodule

// File: rtl/ssr_ctrl.sv
module ssr_ctrl
   import ssr_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 8,
   parameter int SR_OFFS     = 10,
   parameter int AUX_OFFS    = 11,
   parameter int FLAG_OFFS   = 13,
   parameter int MODE_LSB    = 2,
   parameter int FLAG_BIT    = 2,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              tmr_tick,
   input  logic              cb1_in,
   output logic              cb1_out,
   output logic              cb1_oe,
   input  logic              cb2_in,
   output logic              cb2_out,
   output logic              cb2_oe,
   output logic              irq
);

   localparam int CNT_W = $clog2(DATA_W + 1);

   generate
      if (DATA_W < 2)
         begin : g_bad_width $error("ssr_ctrl: DATA_W must be at least 2"); end
      if (MODE_LSB + 3 > DATA_W)
         begin : g_bad_mode $error("ssr_ctrl: mode field outside register"); end
      if (FLAG_BIT >= DATA_W)
         begin : g_bad_flag $error("ssr_ctrl: flag bit outside register"); end
      if (SR_OFFS == AUX_OFFS || SR_OFFS == FLAG_OFFS || AUX_OFFS == FLAG_OFFS)
         begin : g_bad_map $error("ssr_ctrl: register offsets overlap"); end
      if (SR_OFFS >= (1 << ADDR_W) || AUX_OFFS >= (1 << ADDR_W) || FLAG_OFFS >= (1 << ADDR_W))
         begin : g_bad_addr $error("ssr_ctrl: offset beyond address range"); end
      if (SYNC_STAGES < 0)
         begin : g_bad_sync $error("ssr_ctrl: negative sync depth"); end
   endgenerate

   ssr_mode_e         mode;
   logic              sr_wr, sr_acc, tick;
   logic [DATA_W-1:0] sr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              flag_q, cb2_q, pulse_q;

   ssr_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SR_OFFS(SR_OFFS), .AUX_OFFS(AUX_OFFS),
      .FLAG_OFFS(FLAG_OFFS), .MODE_LSB(MODE_LSB), .FLAG_BIT(FLAG_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr_en(reg_wr), .rd_en(reg_rd),
      .wmode(reg_wdata[MODE_LSB +: 3]), .sr_q(sr_q), .flag_q(flag_q),
      .rdata(reg_rdata), .mode(mode), .sr_wr(sr_wr), .sr_acc(sr_acc)
   );

   ssr_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
      .clk(clk), .rst_n(rst_n), .src(mode_src(mode)), .tmr_tick(tmr_tick),
      .cb1_in(cb1_in), .tick(tick)
   );

   ssr_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .mode(mode), .tick(tick), .sr_acc(sr_acc),
      .sr_wr(sr_wr), .wdata(reg_wdata), .cb2_in(cb2_in), .sr_q(sr_q),
      .cnt_q(cnt_q), .flag_q(flag_q), .cb2_q(cb2_q), .pulse_q(pulse_q)
   );

   assign cb1_oe  = mode_drives_clk(mode);
   assign cb1_out = !pulse_q;
   assign cb2_oe  = mode_is_out(mode);
   assign cb2_out = cb2_q;
   assign irq     = flag_q;

endmodule

// File: rtl/ssr_ctrl_chk.sv
module ssr_ctrl_chk
   import ssr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq,
   input logic              cb2_out,
   input logic              cb2_in,
   input logic              tmr_tick,
   input logic              sr_acc,
   input logic [2:0]        mode,
   input logic [CNT_W-1:0]  cnt,
   input logic [DATA_W-1:0] sr
);

   // R3
   acc_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sr_acc |=> !irq);

   // R9
   off_holds_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd0 && $past(mode) == 3'd0) |-> !irq);

   // R7
   spent_holds_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_counted(ssr_mode_e'(mode)) && cnt == '0) |=> $stable(cb2_out));

   // R8
   flag_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(cnt) == CNT_W'(1)));

   // R4
   sys_in_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd2 && cnt != '0 && !sr_acc) |=> (sr[0] == $past(cb2_in)));

   // R5
   free_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd4 && tmr_tick && !sr_acc) |=>
         (sr == {$past(sr[DATA_W-2:0]), $past(sr[DATA_W-1])}));

endmodule

bind ssr_ctrl ssr_ctrl_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq(irq), .cb2_out(cb2_out), .cb2_in(cb2_in),
   .tmr_tick(tmr_tick), .sr_acc(sr_acc), .mode(mode), .cnt(cnt_q), .sr(sr_q)
);

// File: tb/sim_ssr_ctrl.sv
`timescale 1ns/100ps
module sim_ssr_ctrl;

   localparam logic [3:0] A_SR = 4'd10, A_AUX = 4'd11, A_FLG = 4'd13;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic [3:0] reg_addr = '0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_wdata = '0, reg_rdata;
   logic       tmr_tick = 1'b0, cb1_in = 1'b0, cb2_in = 1'b0;
   logic       cb1_out, cb1_oe, cb2_out, cb2_oe, irq;

   always #2.5 clk = ~clk;

   ssr_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_tick(tmr_tick),
      .cb1_in(cb1_in), .cb1_out(cb1_out), .cb1_oe(cb1_oe), .cb2_in(cb2_in),
      .cb2_out(cb2_out), .cb2_oe(cb2_oe), .irq(irq)
   );

   int total = 0, bad = 0;

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] rotl(input logic [7:0] v, input int n);
      logic [7:0] r = v;
      for (int i = 0; i < n; i++) r = {r[6:0], r[7]};
      return r;
   endfunction

   // level on the data line after k shifts of byte v
   function automatic logic out_bit(input logic [7:0] v, input int k);
      logic [7:0] r = rotl(v, k - 1);
      return r[7];
   endfunction

   task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk); reg_addr = a; reg_rd = 1'b1;
      #0.5 d = reg_rdata;
      @(negedge clk); reg_rd = 1'b0;
   endtask

   task automatic tick_bit(input logic b, input int gap);
      cb2_in = b; tmr_tick = 1'b1;
      @(negedge clk); tmr_tick = 1'b0;
      repeat (gap) @(negedge clk);
   endtask

   task automatic ext_pulse(input logic b);
      cb2_in = b; cb1_in = 1'b1;
      @(negedge clk); cb1_in = 1'b0;
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [7:0] d, v, w;
      logic [9:0] p;
      int lows;
      void'($urandom(32'h5eed_2024));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #0.5;
      chk("R1 irq", irq, 0);
      chk("R1 cb1_oe", cb1_oe, 0);
      chk("R1 cb2_oe", cb2_oe, 0);
      chk("R1 cb1_out idle", cb1_out, 1);
      rd_reg(A_AUX, d); chk("R1 mode", d, 8'h00);
      // counted system-clock shift-in with no access yet: nothing enters
      wr_reg(A_AUX, 8'h08); cb2_in = 1'b1;
      repeat (10) @(negedge clk);
      rd_reg(A_SR, d); chk("R1 data idle", d, 8'h00);

      // R2 / R10: mode field readback and line enables in every mode
      for (int m = 0; m < 8; m++) begin
         wr_reg(A_AUX, 8'hE3 | 8'(m << 2));
         rd_reg(A_AUX, d);
         chk("R2 mode readback", d, m << 2);
         chk("R10 cb1_oe", cb1_oe, (m == 1 || m == 2 || m == 4 || m == 5 || m == 6) ? 1 : 0);
         chk("R10 cb2_oe", cb2_oe, (m >= 4) ? 1 : 0);
      end

      // mode 6: system-clock shift-out, random bytes
      for (int it = 0; it < 4; it++) begin
         v = 8'($urandom);
         wr_reg(A_AUX, 8'h18);
         wr_reg(A_SR, v);
         for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            chk("R5 mode6 cb2", cb2_out, out_bit(v, k));
            chk("R10 mode6 pulse", cb1_out, 0);
         end
         chk("R7 mode6 flag", irq, 1);
         for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk("R7 mode6 hold", cb2_out, v[0]);
         end
         chk("R10 pulses stop", cb1_out, 1);
         rd_reg(A_FLG, d); chk("R2 flag bit", d, 8'h04);
         rd_reg(A_SR, d); chk("R5 rotated back", d, v);
         #0.5 chk("R3 read clears", irq, 0);
      end

      // R3: write in the middle of a transfer restarts with the new byte
      v = 8'($urandom); w = ~v ^ 8'h5A;
      wr_reg(A_SR, v);
      repeat (3) @(negedge clk);
      wr_reg(A_SR, w);
      for (int k = 1; k <= 8; k++) begin
         @(negedge clk);
         chk("R3 restart cb2", cb2_out, out_bit(w, k));
      end

      // mode 2: system-clock shift-in, R4 R6 R7 R10
      v = 8'($urandom);
      wr_reg(A_AUX, 8'h08);
      wr_reg(A_SR, 8'h00);
      cb2_in = v[7]; lows = 0;
      for (int i = 6; i >= -1; i--) begin
         @(negedge clk);
         if (!cb1_out) lows++;
         if (i >= 0) cb2_in = v[i];
      end
      repeat (4) begin @(negedge clk); if (!cb1_out) lows++; end
      chk("R10 mode2 pulse count", lows, 8);
      chk("R7 mode2 flag", irq, 1);
      rd_reg(A_SR, d); chk("R4 mode2 data", d, v);

      // mode 1: timer-rate shift-in, extra strobes ignored
      v = 8'($urandom);
      wr_reg(A_AUX, 8'h04);
      wr_reg(A_SR, 8'h00);
      for (int i = 7; i >= 0; i--) tick_bit(v[i], $urandom_range(0, 3));
      chk("R7 mode1 flag", irq, 1);
      for (int i = 0; i < 3; i++) tick_bit(~v[i], 1);
      rd_reg(A_SR, d); chk("R6 mode1 stops after 8", d, v);

      // mode 5: timer-rate shift-out
      v = 8'($urandom);
      wr_reg(A_AUX, 8'h14);
      wr_reg(A_SR, v);
      for (int k = 1; k <= 8; k++) begin
         tick_bit(1'b0, $urandom_range(0, 2));
         chk("R6 mode5 cb2", cb2_out, out_bit(v, k));
      end
      chk("R7 mode5 flag", irq, 1);
      tick_bit(1'b0, 1); tick_bit(1'b0, 1);
      chk("R7 mode5 hold", cb2_out, v[0]);

      // mode 4: free-running recirculation
      v = 8'($urandom) | 8'h01;
      wr_reg(A_AUX, 8'h10);
      wr_reg(A_SR, v);
      for (int k = 0; k < 11; k++) tick_bit(1'b0, $urandom_range(0, 2));
      chk("R9 mode4 no flag", irq, 0);
      chk("R5 mode4 cb2", cb2_out, out_bit(v, 11));
      rd_reg(A_SR, d); chk("R9 mode4 data", d, rotl(v, 11));

      // mode 3: external-clock shift-in, counts but never stops
      p = 10'($urandom);
      wr_reg(A_AUX, 8'h0C);
      wr_reg(A_SR, 8'h00);
      for (int i = 9; i >= 0; i--) begin
         ext_pulse(p[i]);
         if (i == 2) chk("R8 mode3 flag at 8", irq, 1);
      end
      chk("R8 mode3 flag stays", irq, 1);
      rd_reg(A_SR, d); chk("R8 mode3 keeps shifting", d, p[7:0]);
      #0.5 chk("R3 mode3 read clears", irq, 0);

      // mode 7: external-clock shift-out
      v = 8'($urandom);
      wr_reg(A_AUX, 8'h1C);
      wr_reg(A_SR, v);
      for (int k = 1; k <= 16; k++) begin
         ext_pulse(1'b0);
         chk("R6 mode7 cb2", cb2_out, out_bit(v, k));
         if (k == 8) chk("R8 mode7 flag", irq, 1);
      end
      rd_reg(A_SR, d); chk("R8 mode7 data", d, v);

      // mode 0: external shift-in, flag held low
      p = 10'($urandom);
      wr_reg(A_AUX, 8'h00);
      wr_reg(A_SR, 8'hFF);
      for (int i = 8; i >= 0; i--) ext_pulse(p[i]);
      chk("R9 mode0 flag", irq, 0);
      rd_reg(A_SR, d); chk("R4 mode0 data", d, p[7:0]);

      finish_run();
   end

endmodule